// File: doc/BRIEF.md
# Transmit Driver Enable Guard

This block sits between the serial transmit pin of a bus transceiver and its bus output driver. It decides, cycle by cycle, whether the driver may pass transmit data onto the bus. When it does not, the gated output is left recessive (logic high). The decision uses the operating mode, a low-voltage-reset flag, an overtemperature flag whose hysteresis is applied upstream, and the recent history of the transmit pin.

Four rules guard the bus against a faulty transmit source. The driver arms only after transmit data has been sampled high in normal mode, so a pin stuck low from the start never reaches the bus. After a low-voltage reset is released, the output is held recessive for a fixed number of clocks. An overtemperature event disarms the driver until the flag clears and a new high level has been seen. A low run that lasts longer than a set number of bit times is cut off.

Top module: `txd_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `drv_en` is 0 and `bus_out` is 1.
- R2: Whenever `drv_en` is 0, `bus_out` is 1. Whenever `drv_en` is 1, `bus_out` equals `tx_in` in the same cycle.
- R3: After normal mode is entered, `drv_en` stays 0 until `tx_in` has been sampled high at a rising clock edge in normal mode. `drv_en` rises in the cycle that follows that edge.
- R4: While `lvr_active` is 1, `drv_en` is 0. Leaving normal mode clears the armed state, so the next entry into normal mode again needs `tx_in` to be sampled high.
- R5: After `lvr_active` falls, `drv_en` stays 0 for the next 33 clock edges (HOLD_CLKS). Only a high `tx_in` sampled after that period arms the driver. The next low level then reaches the bus.
- R6: In normal mode, `ot_flag` = 1 forces `drv_en` to 0 and disarms the driver. Once `ot_flag` clears, a new high sample of `tx_in` is needed before `drv_en` returns to 1.
- R7: In normal mode, an armed driver passes a low run of `tx_in` for 10 cycles (LOW_LIMIT). From the 11th consecutive low cycle, `drv_en` is 0 and `bus_out` is 1, until `tx_in` is sampled high.
- R8: Any high sample of `tx_in` restarts the low-run count, so each new low run may again pass for 10 cycles.
- R9: Outside normal mode, `drv_en` is 0 and `bus_out` is 1, whatever `tx_in` and `ot_flag` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in | input | 1 | Transmit data from the controller (0 = dominant) |
| normal_mode | input | 1 | 1 when the transceiver is in normal mode |
| lvr_active | input | 1 | 1 while the low-voltage reset is active |
| ot_flag | input | 1 | Overtemperature flag, hysteresis already applied |
| drv_en | output | 1 | Enable for the bus output driver |
| bus_out | output | 1 | Gated bus data, recessive high when disabled |

## Verification
On every cycle, the assertions check the recessive output when the driver is disabled, the forced disable under low-voltage reset, overtemperature and non-normal mode, and the first cycle of normal mode. They also check the 33-clock hold window and the cut-off of long low runs, each against a counter that the checker keeps itself. Only the bench scenarios can show that arming needs a high sample, that the driver re-arms once the overtemperature flag clears, and that a single high level restarts the low-run count. A behavioural reference model compares both outputs on every clock.

// File: rtl/txd_guard_pkg.sv
package txd_guard_pkg;
   localparam int unsigned DEF_HOLD_CLKS = 33;
   localparam int unsigned DEF_LOW_LIMIT = 10;

   typedef struct packed {
      logic armed;
      logic hold_done;
      logic stuck;
   } guard_sts_t;
endpackage

// File: rtl/txd_guard_hold.sv
module txd_guard_hold #(
   parameter int unsigned HOLD_CLKS = 33
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvr_active,
   output logic hold_done
);
   generate
      if (HOLD_CLKS == 0) begin : g_nohold
         assign hold_done = 1'b1;
      end else begin : g_hold
         localparam int unsigned CW = $clog2(HOLD_CLKS + 1);
         localparam logic [CW-1:0] LIM = CW'(HOLD_CLKS);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= LIM;
            else if (lvr_active)     cnt_q <= '0;
            else if (cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
         end
         assign hold_done = (cnt_q == LIM);
      end
   endgenerate
endmodule

// File: rtl/txd_guard_lowrun.sv
module txd_guard_lowrun #(
   parameter int unsigned LOW_LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic normal_mode,
   input  logic tx_in,
   output logic stuck
);
   localparam int unsigned CW = $clog2(LOW_LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LOW_LIMIT);
   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_q <= '0;
      else if (!normal_mode || tx_in)  run_q <= '0;
      else if (run_q != LIM)           run_q <= run_q + 1'b1;
   end

   assign stuck = (run_q == LIM);
endmodule

// File: rtl/txd_guard_arm.sv
module txd_guard_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic normal_mode,
   input  logic lvr_active,
   input  logic ot_flag,
   input  logic hold_done,
   input  logic tx_in,
   output logic armed
);
   logic kill;
   assign kill = !normal_mode || lvr_active || ot_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  armed <= 1'b0;
      else if (kill)               armed <= 1'b0;
      else if (tx_in && hold_done) armed <= 1'b1;
   end
endmodule

// File: rtl/txd_guard.sv
module txd_guard
   import txd_guard_pkg::*;
#(
   parameter int unsigned HOLD_CLKS = DEF_HOLD_CLKS,
   parameter int unsigned LOW_LIMIT = DEF_LOW_LIMIT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_in,
   input  logic normal_mode,
   input  logic lvr_active,
   input  logic ot_flag,
   output logic drv_en,
   output logic bus_out
);
   guard_sts_t sts;

   initial begin
      assert (LOW_LIMIT >= 1) else $error("LOW_LIMIT must be at least 1");
      assert (HOLD_CLKS < 65536) else $error("HOLD_CLKS out of range");
   end

   txd_guard_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
      .clk(clk), .rst_n(rst_n), .lvr_active(lvr_active),
      .hold_done(sts.hold_done)
   );

   txd_guard_lowrun #(.LOW_LIMIT(LOW_LIMIT)) u_low (
      .clk(clk), .rst_n(rst_n), .normal_mode(normal_mode), .tx_in(tx_in),
      .stuck(sts.stuck)
   );

   txd_guard_arm u_arm (
      .clk(clk), .rst_n(rst_n), .normal_mode(normal_mode),
      .lvr_active(lvr_active), .ot_flag(ot_flag),
      .hold_done(sts.hold_done), .tx_in(tx_in), .armed(sts.armed)
   );

   assign drv_en  = sts.armed && sts.hold_done && !sts.stuck &&
                    normal_mode && !lvr_active && !ot_flag;
   assign bus_out = drv_en ? tx_in : 1'b1;
endmodule

// File: rtl/txd_guard_chk.sv
module txd_guard_chk #(
   parameter int unsigned HOLD_CLKS = 33,
   parameter int unsigned LOW_LIMIT = 10
) (
   input logic clk,
   input logic rst_n,
   input logic tx_in,
   input logic normal_mode,
   input logic lvr_active,
   input logic ot_flag,
   input logic drv_en,
   input logic bus_out
);
   int unsigned since_lvr;
   int unsigned low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_lvr <= HOLD_CLKS;
         low_run   <= 0;
      end else begin
         if (lvr_active)               since_lvr <= 0;
         else if (since_lvr < HOLD_CLKS) since_lvr <= since_lvr + 1;
         if (!normal_mode || tx_in)    low_run <= 0;
         else if (low_run < LOW_LIMIT) low_run <= low_run + 1;
      end
   end

   assert_recessive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |-> bus_out);
   assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (bus_out == tx_in));
   assert_first_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(normal_mode) |-> !drv_en);
   assert_lvr_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lvr_active |-> !drv_en);
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (since_lvr < HOLD_CLKS) |-> !drv_en);
   assert_ot_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ot_flag && normal_mode) |-> !drv_en);
   assert_cutoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (low_run >= LOW_LIMIT) |-> bus_out);
   assert_sleep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !normal_mode |-> (!drv_en && bus_out));
endmodule

bind txd_guard txd_guard_chk #(.HOLD_CLKS(HOLD_CLKS), .LOW_LIMIT(LOW_LIMIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .normal_mode(normal_mode),
   .lvr_active(lvr_active), .ot_flag(ot_flag), .drv_en(drv_en), .bus_out(bus_out)
);

// File: tb/tb_txd_guard.sv
module tb_txd_guard;
   localparam int PERIOD = 10;
   localparam int HOLD   = 33;
   localparam int LIMIT  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_in = 1'b1, normal_mode = 1'b0, lvr_active = 1'b0, ot_flag = 1'b0;
   logic drv_en, bus_out;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   txd_guard dut (
      .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .normal_mode(normal_mode),
      .lvr_active(lvr_active), .ot_flag(ot_flag),
      .drv_en(drv_en), .bus_out(bus_out)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference
   int m_hold = HOLD;
   int m_low  = 0;
   bit m_arm  = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hold = HOLD; m_low = 0; m_arm = 0;
      end else begin
         if (!normal_mode || lvr_active || ot_flag) m_arm = 0;
         else if (tx_in && m_hold >= HOLD)          m_arm = 1;
         if (lvr_active)          m_hold = 0;
         else if (m_hold < HOLD)  m_hold = m_hold + 1;
         if (!normal_mode || tx_in) m_low = 0;
         else if (m_low < LIMIT)    m_low = m_low + 1;
      end
   end

   function automatic bit exp_en();
      return m_arm && m_hold >= HOLD && m_low < LIMIT &&
             normal_mode && !lvr_active && !ot_flag;
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e;
         e = exp_en();
         checks++;
         if (drv_en !== e || bus_out !== (e ? tx_in : 1'b1)) begin
            errors++;
            $display("FAIL model R2/R3/R5/R7: drv_en=%b bus_out=%b expected drv_en=%b bus_out=%b",
                     drv_en, bus_out, e, e ? tx_in : 1'b1);
         end
      end
   end

   task automatic chk(input string tag, input logic act_en, input logic act_bus,
                      input logic e_en, input logic e_bus);
      checks++;
      if (act_en !== e_en || act_bus !== e_bus) begin
         errors++;
         $display("FAIL %s: drv_en=%b bus_out=%b expected drv_en=%b bus_out=%b",
                  tag, act_en, act_bus, e_en, e_bus);
      end
   endtask

   task automatic step(input logic t, input logic n, input logic l, input logic o);
      @(posedge clk);
      #1;
      tx_in = t; normal_mode = n; lvr_active = l; ot_flag = o;
      #(PERIOD/4);
   endtask

   initial begin
      #(PERIOD*3);
      chk("R1 in reset", drv_en, bus_out, 0, 1);
      @(posedge clk); #1 rst_n = 1'b1;
      #(PERIOD/4);
      chk("R1 after reset", drv_en, bus_out, 0, 1);

      // R9: sleep ignores tx and ot
      step(0, 0, 0, 1);
      chk("R9 sleep", drv_en, bus_out, 0, 1);

      // R3: arm on high sample
      step(0, 1, 0, 0);
      chk("R3 enter low", drv_en, bus_out, 0, 1);
      step(0, 1, 0, 0);
      chk("R3 still low", drv_en, bus_out, 0, 1);
      step(1, 1, 0, 0);
      chk("R3 high not yet sampled", drv_en, bus_out, 0, 1);
      step(0, 1, 0, 0);
      chk("R3 armed R2 pass low", drv_en, bus_out, 1, 0);

      // R7: stuck low cut off
      for (int i = 2; i <= LIMIT; i++) begin
         step(0, 1, 0, 0);
         chk("R7 low within limit", drv_en, bus_out, 1, 0);
      end
      step(0, 1, 0, 0);
      chk("R7 cut off", drv_en, bus_out, 0, 1);
      step(0, 1, 0, 0);
      chk("R7 stays cut", drv_en, bus_out, 0, 1);

      // R8: high restarts count
      step(1, 1, 0, 0);
      step(0, 1, 0, 0);
      chk("R8 restart", drv_en, bus_out, 1, 0);
      for (int i = 2; i <= 5; i++) step(0, 1, 0, 0);
      step(1, 1, 0, 0);
      for (int i = 1; i <= LIMIT; i++) step(0, 1, 0, 0);
      chk("R8 full run after high", drv_en, bus_out, 1, 0);

      // R4: leaving normal clears arm
      step(1, 0, 0, 0);
      chk("R9 left normal", drv_en, bus_out, 0, 1);
      step(0, 1, 0, 0);
      chk("R4 rearm needed", drv_en, bus_out, 0, 1);
      step(1, 1, 0, 0);
      step(0, 1, 0, 0);
      chk("R4 rearmed", drv_en, bus_out, 1, 0);

      // R6: overtemperature
      step(0, 1, 0, 1);
      chk("R6 ot active", drv_en, bus_out, 0, 1);
      step(0, 1, 0, 0);
      chk("R6 cleared needs high", drv_en, bus_out, 0, 1);
      step(1, 1, 0, 0);
      step(0, 1, 0, 0);
      chk("R6 rearmed", drv_en, bus_out, 1, 0);

      // R4/R5: low-voltage reset and hold
      step(1, 1, 1, 0);
      chk("R4 lvr active", drv_en, bus_out, 0, 1);
      for (int i = 1; i <= HOLD + 1; i++) step(1, 1, 0, 0);
      chk("R5 last held cycle", drv_en, bus_out, 0, 1);
      step(0, 1, 0, 0);
      chk("R5 first falling edge passes", drv_en, bus_out, 1, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(PERIOD*200000);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule